// File: doc/BRIEF.md
# Time-Multiplexed Cellular Automaton Delay-Line Bank

The block keeps the states of N small virtual machines in a bank of W-bit recirculating shift lines, N slots deep. On every clock while running, the slot at the end of the lines leaves all W lines together. It passes through a single shared transition unit, and the new state re-enters the head of the lines. A full generation therefore takes N clocks, and one transition circuit serves all N machines in turn. A slot counter shows which machine is at the tap, and a frame flag marks slot 0.

In this build the transition unit runs a one-dimensional elementary cellular automaton on bit 0 of each state. The left neighbour comes from a one-bit latch that holds the previous machine's pre-transition cell. At slot 0 it is taken from the head of the line instead. The right neighbour is the slot just behind the tap. At the last slot it comes from an auxiliary line N-1 stages long, which still holds machine 0's cell from before its update. Every machine is therefore updated from one consistent generation, including across the ring seam. The upper state bits keep a short history of the cell plus a sticky flag.

When run is low the lines freeze. A host port can then write or read any machine by its index, wherever that machine currently sits in the lines, and a synchronous clear can empty the bank.

Top module: `dlm_bank`

## Requirements
- R1: After reset every machine state reads zero, the slot output is 0 and frame is high.
- R2: While run is high the slot output advances by one per clock and wraps from N-1 to 0. Frame is high exactly when the slot is 0.
- R3: While run is low the line contents, the slot and the neighbour latch hold their values.
- R4: While run is low, a write with host_we high stores host_wdata into the machine whose index is host_addr. host_rdata shows that machine's state in the same cycle as host_addr is applied, at any slot position.
- R5: host_we has no effect on any state while run is high.
- R6: A clear while run is low sets every state and the slot to zero on the next clock. Clear has no effect while run is high.
- R7: N run clocks starting from slot 0 give one synchronous generation on a ring. The new bit 0 of machine k is rule[4*left + 2*centre + right], where left is bit 0 of machine k-1, centre is bit 0 of machine k, and right is bit 0 of machine k+1, all taken from the previous generation, with indices modulo N.
- R8: On each transition, state bits W-2 down to 1 take the previous bits W-3 down to 0. Bit W-1 becomes the OR of the previous bits W-1 and W-2.
- R9: A generation halted after S clocks shows machines 0..S-1 already advanced and machines S..N-1 unchanged. Resuming for the remaining N-S clocks gives the same result as an uninterrupted generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Advances the lines one slot per clock when high |
| clear | input | 1 | Zeros all states and the slot counter while halted |
| rule | input | 8 | Cellular automaton rule table indexed by {left, centre, right} |
| host_we | input | 1 | Host write strobe, honoured only while halted |
| host_addr | input | log2(N) | Machine index for host read and write |
| host_wdata | input | W | State to write |
| host_rdata | output | W | State of the addressed machine |
| slot | output | log2(N) | Index of the machine at the tap |
| frame | output | 1 | High when slot is 0 |

## Verification
Rule 110 is started from a single live cell, which shows whether neighbours are picked up on the correct side. A lone cell at machine 0 lights machine N-1 only when the auxiliary line supplies the right neighbour across the seam. A lone cell at machine N-1 under rule 90 does the same for the left neighbour at slot 0. Pseudo-random starting patterns under rules 30 and 90 exercise all eight rule indices together with the history bits. A generation halted halfway is read back to separate the address mapping from the update order, and host writes made while running must leave no trace.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  // New cell value looked up from the rule table, left neighbour as MSB
  function automatic logic ca_bit(input logic [7:0] rule, input logic l,
                                  input logic c, input logic r);
    return rule[{l, c, r}];
  endfunction
endpackage

// File: rtl/dlm_line.sv
// W-wide recirculating line of LEN slots with a host access port.
module dlm_line #(
  parameter int WIDTH = 8,
  parameter int LEN   = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [AW-1:0]    pos,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] wr_data,
  output logic             head_bit,
  output logic             near_bit,
  output logic [WIDTH-1:0] q_last,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] cell_q [LEN];
  logic [WIDTH-1:0] cell_d [LEN];

  always_comb begin
    for (int i = 0; i < LEN; i++) cell_d[i] = cell_q[i];
    if (clr) begin
      for (int i = 0; i < LEN; i++) cell_d[i] = '0;
    end else if (en) begin
      cell_d[0] = din;
      for (int i = 1; i < LEN; i++) cell_d[i] = cell_q[i-1];
    end else if (wr_en && (int'(pos) < LEN)) begin
      cell_d[pos] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LEN; i++) cell_q[i] <= '0;
    end else begin
      for (int i = 0; i < LEN; i++) cell_q[i] <= cell_d[i];
    end
  end

  assign head_bit = cell_q[0][0];
  assign near_bit = cell_q[LEN-2][0];
  assign q_last   = cell_q[LEN-1];
  assign rd_data  = (int'(pos) < LEN) ? cell_q[pos] : '0;
endmodule

// File: rtl/dlm_delay.sv
// One-bit auxiliary delay line, LEN stages.
module dlm_delay #(
  parameter int LEN = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (clr)     sr_d = '0;
    else if (en) begin
      if (LEN > 1) sr_d = {sr_q[LEN-2:0], din};
      else         sr_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign dout = sr_q[LEN-1];
endmodule

// File: rtl/dlm_slot.sv
// Slot counter and mapping from machine index to line position.
module dlm_slot #(
  parameter int N  = 64,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] slot,
  output logic [AW-1:0] pos
);
  localparam logic [AW-1:0] LAST = AW'(N-1);
  localparam logic [AW:0]   NN   = (AW+1)'(N);

  logic [AW-1:0] slot_q, slot_d;
  logic [AW:0]   off;

  always_comb begin
    slot_d = slot_q;
    if (clr)     slot_d = '0;
    else if (en) slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  // Machine slot+k sits k places before the tap end of the line
  always_comb begin
    if (idx >= slot_q) off = {1'b0, idx} - {1'b0, slot_q};
    else               off = {1'b0, idx} + NN - {1'b0, slot_q};
    pos = AW'((NN - 1'b1) - off);
  end

  assign slot = slot_q;
endmodule

// File: rtl/dlm_xfer.sv
// Shared transition unit: cell update plus history shift.
module dlm_xfer #(
  parameter int W = 8
) (
  input  logic [7:0]   rule,
  input  logic [W-1:0] cur,
  input  logic         left,
  input  logic         right,
  output logic [W-1:0] nxt
);
  import dlm_pkg::*;

  always_comb begin
    nxt[0]   = ca_bit(rule, left, cur[0], right);
    nxt[W-1] = cur[W-1] | cur[W-2];
    for (int b = 1; b < W-1; b++) nxt[b] = cur[b-1];
  end
endmodule

// File: rtl/dlm_bank.sv
module dlm_bank #(
  parameter int  N  = 64,
  parameter int  W  = 8,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clear,
  input  logic [7:0]    rule,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  output logic [AW-1:0] slot,
  output logic          frame
);
  localparam logic [AW-1:0] LAST = AW'(N-1);

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic          clr_en, wr_en;
  logic          head_bit, near_bit, aux_bit;
  logic          left_q, left_d, left_nb, right_nb;
  logic [W-1:0]  tap, fresh;
  logic [AW-1:0] pos;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign clr_en = clear & ~run;
  assign wr_en  = host_we & ~run;

  dlm_slot #(.N(N), .AW(AW)) u_slot (
    .clk(clk), .rst_n(rst_sync_n), .en(run), .clr(clr_en),
    .idx(host_addr), .slot(slot), .pos(pos)
  );

  dlm_line #(.WIDTH(W), .LEN(N), .AW(AW)) u_line (
    .clk(clk), .rst_n(rst_sync_n), .en(run), .clr(clr_en), .wr_en(wr_en),
    .pos(pos), .din(fresh), .wr_data(host_wdata),
    .head_bit(head_bit), .near_bit(near_bit), .q_last(tap), .rd_data(host_rdata)
  );

  // Holds each machine's pre-update cell for N-1 slots
  dlm_delay #(.LEN(N-1)) u_aux (
    .clk(clk), .rst_n(rst_sync_n), .en(run), .clr(clr_en),
    .din(tap[0]), .dout(aux_bit)
  );

  // Latch carrying the previous machine's cell to the next one
  always_comb begin
    left_d = left_q;
    if (clr_en)   left_d = 1'b0;
    else if (run) left_d = tap[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= 1'b0;
    else        left_q <= left_d;
  end

  assign left_nb  = (slot == '0)  ? head_bit : left_q;
  assign right_nb = (slot == LAST) ? aux_bit  : near_bit;

  dlm_xfer #(.W(W)) u_xfer (
    .rule(rule), .cur(tap), .left(left_nb), .right(right_nb), .nxt(fresh)
  );

  assign frame = (slot == '0);
endmodule

// File: rtl/dlm_bank_chk.sv
module dlm_bank_chk #(
  parameter int  N  = 64,
  parameter int  W  = 8,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          run,
  input logic          clear,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic [W-1:0]  host_wdata,
  input logic [W-1:0]  host_rdata,
  input logic [AW-1:0] slot,
  input logic          frame
);
  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run |=> slot == (($past(slot) == AW'(N-1)) ? AW'(0) : AW'($past(slot) + 1'b1)));

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && slot == AW'(N-1)) |=> frame);

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !clear) |=> $stable(slot));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && clear) |=> (slot == '0 && host_rdata == '0));

  // R4
  host_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !clear && host_we) |=>
      ((host_addr != $past(host_addr)) || (host_rdata == $past(host_wdata))));
endmodule

bind dlm_bank dlm_bank_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .run(run), .clear(clear),
  .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .slot(slot), .frame(frame)
);

// File: tb/sim_dlm_bank.sv
`timescale 1ns/1ps
module sim_dlm_bank;
  localparam int N  = 64;
  localparam int W  = 8;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          clear = 1'b0;
  logic [7:0]    rule = 8'd110;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [W-1:0]  host_wdata = '0;
  logic [W-1:0]  host_rdata;
  logic [AW-1:0] slot;
  logic          frame;

  always #10 clk = ~clk;

  dlm_bank #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(clear), .rule(rule),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .slot(slot), .frame(frame)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic mon_en = 1'b0;
  logic [W-1:0] exp_q [$];
  string        tag_q [$];
  logic [W-1:0] ref_st [N];
  logic [W-1:0] nx_st  [N];
  logic [15:0]  lf = 16'hACE1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_q.size() == 0) chk("scoreboard underrun", 32'(host_rdata), 32'hFFFF_FFFF);
      else chk(tag_q.pop_front(), 32'(host_rdata), 32'(exp_q.pop_front()));
    end
  end

  // Driver: addresses every machine and queues its expected state
  task automatic read_all(input string tag, input logic use_mix, input int split);
    for (int i = 0; i < N; i++) begin
      @(posedge clk); #1;
      host_addr = AW'(i);
      exp_q.push_back((use_mix && i >= split) ? ref_st[i] : (use_mix ? nx_st[i] : ref_st[i]));
      tag_q.push_back($sformatf("%s machine %0d", tag, i));
      mon_en = 1'b1;
    end
    @(posedge clk); #1;
    mon_en = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < N; i++) begin
      @(posedge clk); #1;
      host_we = 1'b1; host_addr = AW'(i); host_wdata = ref_st[i];
    end
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic run_steps(input int n, input logic [7:0] rl, input logic poke);
    @(posedge clk); #1;
    rule = rl; run = 1'b1;
    if (poke) begin host_we = 1'b1; host_addr = 6'd5; host_wdata = 8'hA5; end
    repeat (n) @(posedge clk);
    #1;
    run = 1'b0; host_we = 1'b0;
  endtask

  // Reference model: one synchronous generation into nx_st
  task automatic ref_gen(input logic [7:0] rl);
    for (int k = 0; k < N; k++) begin
      logic l, c, r;
      l = ref_st[(k + N - 1) % N][0];
      c = ref_st[k][0];
      r = ref_st[(k + 1) % N][0];
      nx_st[k] = {ref_st[k][W-1] | ref_st[k][W-2], ref_st[k][W-3:0], rl[{l, c, r}]};
    end
  endtask

  task automatic commit();
    for (int k = 0; k < N; k++) ref_st[k] = nx_st[k];
  endtask

  task automatic generation(input logic [7:0] rl, input string tag, input logic poke);
    run_steps(N, rl, poke);
    ref_gen(rl);
    commit();
    read_all(tag, 1'b0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) ref_st[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1
    chk("R1 slot after reset", 32'(slot), 32'd0);
    chk("R1 frame after reset", 32'(frame), 32'd1);
    read_all("R1 reset state", 1'b0, 0);

    // R4: load a single live cell at N-1 with patterned history bits
    for (int k = 0; k < N; k++) ref_st[k] = 8'((k * 29 + 3) & 8'hFE) | 8'(k == N-1);
    load_all();
    read_all("R4 host load", 1'b0, 0);

    // R7 R8: rule 110 for four generations; R5 host writes during the second
    generation(8'd110, "R7 rule110 gen1", 1'b0);
    generation(8'd110, "R5 write while running", 1'b1);
    generation(8'd110, "R7 rule110 gen3", 1'b0);
    generation(8'd110, "R8 rule110 gen4", 1'b0);

    // R9: halt halfway, check the mix, idle, resume
    run_steps(N/2, 8'd110, 1'b0);
    chk("R2 slot at halfway", 32'(slot), 32'(N/2));
    chk("R2 frame off at halfway", 32'(frame), 32'd0);
    ref_gen(8'd110);
    read_all("R9 halted mid generation", 1'b1, N/2);
    repeat (5) @(posedge clk);
    #1;
    chk("R3 slot frozen while halted", 32'(slot), 32'(N/2));
    run_steps(N/2, 8'd110, 1'b0);
    chk("R2 slot wrapped to 0", 32'(slot), 32'd0);
    chk("R2 frame at slot 0", 32'(frame), 32'd1);
    commit();
    read_all("R9 resumed generation", 1'b0, 0);

    // R6: clear zeros everything
    @(posedge clk); #1 clear = 1'b1;
    @(posedge clk); #1 clear = 1'b0;
    for (int k = 0; k < N; k++) ref_st[k] = '0;
    chk("R6 slot after clear", 32'(slot), 32'd0);
    read_all("R6 after clear", 1'b0, 0);

    // R7: right neighbour across the seam (lone cell at 0, rule 110)
    ref_st[0] = 8'h01;
    load_all();
    generation(8'd110, "R7 seam right neighbour", 1'b0);

    // R7: left neighbour across the seam (lone cell at N-1, rule 90)
    for (int k = 0; k < N; k++) ref_st[k] = '0;
    ref_st[N-1] = 8'h01;
    @(posedge clk); #1 clear = 1'b1;
    @(posedge clk); #1 clear = 1'b0;
    load_all();
    generation(8'd90, "R7 seam left neighbour", 1'b0);

    // R7 R8: pseudo-random patterns under rules 30 and 90
    for (int k = 0; k < N; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ref_st[k] = lf[7:0];
    end
    load_all();
    generation(8'd30, "R7 rule30 gen1", 1'b0);
    generation(8'd30, "R8 rule30 gen2", 1'b0);
    generation(8'd30, "R7 rule30 gen3", 1'b0);
    generation(8'd90, "R7 rule90 gen1", 1'b0);
    generation(8'd90, "R8 rule90 gen2", 1'b0);

    summary();
    $finish;
  end
endmodule